// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block connects a single-word host request port to a 32-bit single-data-rate synchronous DRAM with four banks, each holding 4096 rows of 512 words. On reset it first waits a power-up delay, then precharges all banks. It then issues two auto-refresh cycles and programs the mode register. After that it raises `ready` and starts serving requests.

Each host request is one word. The block opens the addressed row with an activate command and then issues a column read or write with auto precharge, so the row closes by itself. A refresh scheduler counts down one refresh interval, derived from the clock frequency. A refresh that falls due is always issued ahead of any waiting host request. Read data returns with a one-cycle valid strobe after the CAS latency, which is chosen at initialisation as 2 or 3.

The DRAM data bus is presented split into a driven word, an output enable and a sampled word, so that the pad ring can build the tristate.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: After reset, `ready` stays low and only NOP (1111 or 0111) is driven. After the power-up delay the command order is PRECHARGE with A10=1, REFRESH, REFRESH, LOAD MODE. `ready` rises after LOAD MODE and stays high until the next reset.
- R2: The LOAD MODE address word has bits [2:0]=000 (burst of one) and bit 3=0 (sequential). Bits [6:4] hold the CAS latency: 2 when `cfg_cl3`=0 and 3 when it is 1. All other bits are 0, and the bank is 0. `cfg_cl3` is sampled only at LOAD MODE; changes after that have no effect on read latency.
- R3: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as follows: NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, LOAD MODE 0000. No other code is ever driven.
- R4: The host address splits as bank = addr[22:21], row = addr[20:9] and column = addr[8:0]. ACTIVATE carries the bank and the row on A[11:0]. READ and WRITE carry the same bank, the column on A[8:0], A10=1 (auto precharge) and zero on the other address bits.
- R5: The READ or WRITE for a request is issued exactly TRCD cycles after its ACTIVATE.
- R6: A WRITE drives the host word on the data bus with the output enable high, in the same cycle as the command, and DQM[i] = ~be[i]. A READ drives DQM = 0000 and leaves the output enable low.
- R7: Read data is captured CL clocks after the DRAM samples the READ command. `rd_valid` is high for one cycle, one clock later, and carries the addressed word.
- R8: A refresh falls due every REF_CYC clocks once `ready` is high. A due refresh is issued before any further ACTIVATE. The time between successive refreshes never exceeds REF_CYC plus the length of one access.
- R9: `ack` pulses for one cycle, in the cycle the ACTIVATE for that request is driven. Each pulse accepts exactly one request.
- R10: Only NOP is driven between commands. The next command follows a PRECHARGE after at least TRP cycles, a REFRESH after at least TRFC, a LOAD MODE after at least TMRD, a WRITE after at least TWR+TRP, and a READ after at least CL+TRP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cl3 | input | 1 | CAS latency select: 0 gives 2, 1 gives 3 |
| req_i | input | 1 | Host request valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 23 | {bank, row, column} word address |
| req_wdata_i | input | 32 | Write data |
| req_be_i | input | 4 | Byte enables for the write |
| ack_o | output | 1 | Request accepted |
| rd_data_o | output | 32 | Returned read word |
| rd_valid_o | output | 1 | Read word valid strobe |
| ready_o | output | 1 | Initialisation complete |
| sd_cs_n | output | 1 | DRAM chip select |
| sd_ras_n | output | 1 | DRAM row strobe |
| sd_cas_n | output | 1 | DRAM column strobe |
| sd_we_n | output | 1 | DRAM write enable |
| sd_ba | output | 2 | DRAM bank address |
| sd_a | output | 12 | DRAM address lines |
| sd_dqm | output | 4 | DRAM byte masks |
| sd_dq_o | output | 32 | Data to DRAM |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_i | input | 32 | Data from DRAM |

## Verification
Every command is registered, so the bench's DRAM model sees each command one edge after the controller decides on it. The model timestamps each command on its own cycle counter.

The bench checks that the READ or WRITE follows its ACTIVATE by exactly TRCD model cycles. It checks that `rd_valid` is first seen CL+1 model cycles after the READ was sampled, and that each command gap is at least the wait that belongs to the previous command. Host-side checks sample on the falling edge. Each task holds its expected address and data until the model has seen the column command, so that every comparison uses the request that is actually in flight.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  localparam int BANK_W  = 2;
  localparam int ROW_W   = 12;
  localparam int COL_W   = 9;
  localparam int DATA_W  = 32;
  localparam int BYTES   = DATA_W / 8;
  localparam int HADDR_W = BANK_W + ROW_W + COL_W;
  localparam int SDA_W   = ROW_W;
  localparam int AP_BIT  = 10;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT, ST_PRE, ST_IREF1, ST_IREF2, ST_MRS, ST_IDLE, ST_RW
  } seq_st_e;

  function automatic logic [BANK_W-1:0] addr_bank(input logic [HADDR_W-1:0] ad);
    return ad[HADDR_W-1 -: BANK_W];
  endfunction

  function automatic logic [ROW_W-1:0] addr_row(input logic [HADDR_W-1:0] ad);
    return ad[COL_W +: ROW_W];
  endfunction

  function automatic logic [COL_W-1:0] addr_col(input logic [HADDR_W-1:0] ad);
    return ad[COL_W-1:0];
  endfunction

  // burst of one, sequential, latency in bits 6:4
  function automatic logic [SDA_W-1:0] mode_word(input logic cl3);
    logic [SDA_W-1:0] m;
    m = '0;
    m[6:4] = cl3 ? 3'd3 : 3'd2;
    return m;
  endfunction

  function automatic logic [SDA_W-1:0] col_word(input logic [COL_W-1:0] c);
    logic [SDA_W-1:0] w;
    w = '0;
    w[COL_W-1:0] = c;
    w[AP_BIT] = 1'b1;
    return w;
  endfunction

  function automatic int post_gap(input logic wr, input logic cl3,
                                  input int twr, input int trp);
    return wr ? (twr + trp) : ((cl3 ? 3 : 2) + trp);
  endfunction

  // value loaded into the wait counter for a command-to-command gap
  function automatic int gap_load(input int w);
    return (w < 2) ? 0 : (w - 2);
  endfunction
endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int REF_CYC = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic serve,
  output logic pending
);
  localparam int W = $clog2(REF_CYC + 1);

  logic [W-1:0] cnt_q;
  logic         expire;

  assign expire = en && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= W'(REF_CYC - 1);
      pending <= 1'b0;
    end else begin
      if (!en || expire) cnt_q <= W'(REF_CYC - 1);
      else               cnt_q <= cnt_q - 1'b1;
      if (expire)        pending <= 1'b1;
      else if (serve)    pending <= 1'b0;
    end
  end

  assert_expire_sets_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pending);
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
  import sdram_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cl3,
  input  logic              rd_on_bus,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [2:0] sh_q;
  logic       tap;

  assign tap = cl3 ? sh_q[2] : sh_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      sh_q   <= {sh_q[1:0], rd_on_bus};
      rvalid <= tap;
      if (tap) rdata <= dq_in;
    end
  end

  assert_rvalid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm
  import sdram_seq_pkg::*;
#(
  parameter int PWRUP_CYC = 5000,
  parameter int TRCD      = 3,
  parameter int TRP       = 3,
  parameter int TRFC      = 7,
  parameter int TMRD      = 2,
  parameter int TWR       = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_cl3,
  input  logic               req,
  input  logic               req_we,
  input  logic [HADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [BYTES-1:0]   req_be,
  input  logic               ref_pending,
  output logic               ref_serve,
  output logic               ack,
  output logic               ready,
  output logic               cl3,
  output sd_cmd_e            cmd,
  output logic [BANK_W-1:0]  ba,
  output logic [SDA_W-1:0]   a,
  output logic [BYTES-1:0]   dqm,
  output logic [DATA_W-1:0]  dq_out,
  output logic               dq_oe
);
  localparam int CNT_W = $clog2(PWRUP_CYC + TRFC + TRP + TWR + TRCD + TMRD + 8);

  seq_st_e            st_q, st_n, aft_q, aft_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  sd_cmd_e            cmd_n;
  logic [BANK_W-1:0]  ba_n;
  logic [SDA_W-1:0]   a_n;
  logic [BYTES-1:0]   dqm_n;
  logic [DATA_W-1:0]  dout_n;
  logic               oe_n, ack_n, ready_n, cl3_n;
  logic               lat_we_q, lat_we_n;
  logic [HADDR_W-1:0] lat_addr_q, lat_addr_n;
  logic [DATA_W-1:0]  lat_wd_q, lat_wd_n;
  logic [BYTES-1:0]   lat_be_q, lat_be_n;
  logic               wait_done;

  assign wait_done = (st_q == ST_WAIT) && (cnt_q == '0);

  always_comb begin
    st_n = st_q;  aft_n = aft_q;  cnt_n = cnt_q;
    cmd_n = CMD_NOP;  ba_n = ba;  a_n = a;  dqm_n = '1;
    dout_n = dq_out;  oe_n = 1'b0;  ack_n = 1'b0;  ref_serve = 1'b0;
    cl3_n = cl3;
    lat_we_n = lat_we_q; lat_addr_n = lat_addr_q; lat_wd_n = lat_wd_q; lat_be_n = lat_be_q;
    ready_n = ready | (wait_done && aft_q == ST_IDLE);
    unique case (st_q)
      ST_WAIT: begin
        if (cnt_q == '0) st_n = aft_q;
        else             cnt_n = cnt_q - 1'b1;
      end
      ST_PRE: begin
        cmd_n = CMD_PRE;  a_n = '0;  a_n[AP_BIT] = 1'b1;
        st_n = ST_WAIT;  aft_n = ST_IREF1;  cnt_n = CNT_W'(gap_load(TRP));
      end
      ST_IREF1: begin
        cmd_n = CMD_REF;
        st_n = ST_WAIT;  aft_n = ST_IREF2;  cnt_n = CNT_W'(gap_load(TRFC));
      end
      ST_IREF2: begin
        cmd_n = CMD_REF;
        st_n = ST_WAIT;  aft_n = ST_MRS;  cnt_n = CNT_W'(gap_load(TRFC));
      end
      ST_MRS: begin
        cmd_n = CMD_MRS;  ba_n = '0;  a_n = mode_word(cfg_cl3);  cl3_n = cfg_cl3;
        st_n = ST_WAIT;  aft_n = ST_IDLE;  cnt_n = CNT_W'(gap_load(TMRD));
      end
      ST_IDLE: begin
        if (ref_pending) begin
          cmd_n = CMD_REF;  ref_serve = 1'b1;
          st_n = ST_WAIT;  aft_n = ST_IDLE;  cnt_n = CNT_W'(gap_load(TRFC));
        end else if (req) begin
          cmd_n = CMD_ACT;  ba_n = addr_bank(req_addr);  a_n = addr_row(req_addr);
          ack_n = 1'b1;
          lat_we_n = req_we;  lat_addr_n = req_addr;  lat_wd_n = req_wdata;  lat_be_n = req_be;
          st_n = ST_WAIT;  aft_n = ST_RW;  cnt_n = CNT_W'(gap_load(TRCD));
        end
      end
      ST_RW: begin
        cmd_n = lat_we_q ? CMD_WR : CMD_RD;
        ba_n  = addr_bank(lat_addr_q);
        a_n   = col_word(addr_col(lat_addr_q));
        if (lat_we_q) begin
          oe_n = 1'b1;  dout_n = lat_wd_q;  dqm_n = ~lat_be_q;
        end else begin
          dqm_n = '0;
        end
        st_n = ST_WAIT;  aft_n = ST_IDLE;
        cnt_n = CNT_W'(gap_load(post_gap(lat_we_q, cl3, TWR, TRP)));
      end
      default: st_n = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_WAIT;  aft_q <= ST_PRE;  cnt_q <= CNT_W'(gap_load(PWRUP_CYC));
      cmd <= CMD_NOP;  ba <= '0;  a <= '0;  dqm <= '1;  dq_out <= '0;  dq_oe <= 1'b0;
      ack <= 1'b0;  ready <= 1'b0;  cl3 <= 1'b0;
      lat_we_q <= 1'b0;  lat_addr_q <= '0;  lat_wd_q <= '0;  lat_be_q <= '0;
    end else begin
      st_q <= st_n;  aft_q <= aft_n;  cnt_q <= cnt_n;
      cmd <= cmd_n;  ba <= ba_n;  a <= a_n;  dqm <= dqm_n;  dq_out <= dout_n;  dq_oe <= oe_n;
      ack <= ack_n;  ready <= ready_n;  cl3 <= cl3_n;
      lat_we_q <= lat_we_n;  lat_addr_q <= lat_addr_n;  lat_wd_q <= lat_wd_n;  lat_be_q <= lat_be_n;
    end
  end

  // age of the last activate on the bus, for the TRCD check
  logic [7:0] act_age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 act_age_q <= '0;
    else if (cmd == CMD_ACT)    act_age_q <= 8'd1;
    else if (act_age_q != '1 && act_age_q != '0) act_age_q <= act_age_q + 1'b1;
  end

  assert_rw_after_trcd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> (act_age_q >= 8'(TRCD)));
  assert_ack_yields_to_refresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !$past(ref_pending));
  assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_wdata_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WR) |-> dq_oe);
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int CLK_MHZ   = 50,
  parameter int PWRUP_US  = 100,
  parameter int REF_NS    = 15625,
  parameter int TRCD      = 3,
  parameter int TRP       = 3,
  parameter int TRFC      = 7,
  parameter int TMRD      = 2,
  parameter int TWR       = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_cl3,
  input  logic        req_i,
  input  logic        req_we_i,
  input  logic [22:0] req_addr_i,
  input  logic [31:0] req_wdata_i,
  input  logic [3:0]  req_be_i,
  output logic        ack_o,
  output logic [31:0] rd_data_o,
  output logic        rd_valid_o,
  output logic        ready_o,
  output logic        sd_cs_n,
  output logic        sd_ras_n,
  output logic        sd_cas_n,
  output logic        sd_we_n,
  output logic [1:0]  sd_ba,
  output logic [11:0] sd_a,
  output logic [3:0]  sd_dqm,
  output logic [31:0] sd_dq_o,
  output logic        sd_dq_oe,
  input  logic [31:0] sd_dq_i
);
  localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
  localparam int REF_CYC   = (CLK_MHZ * REF_NS) / 1000;

  sd_cmd_e cmd;
  logic    ref_pending, ref_serve, cl3;

  sdram_ref_timer #(.REF_CYC(REF_CYC)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(ready_o), .serve(ref_serve), .pending(ref_pending)
  );

  sdram_cmd_fsm #(
    .PWRUP_CYC(PWRUP_CYC), .TRCD(TRCD), .TRP(TRP), .TRFC(TRFC), .TMRD(TMRD), .TWR(TWR)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_cl3(cfg_cl3),
    .req(req_i), .req_we(req_we_i), .req_addr(req_addr_i),
    .req_wdata(req_wdata_i), .req_be(req_be_i),
    .ref_pending(ref_pending), .ref_serve(ref_serve),
    .ack(ack_o), .ready(ready_o), .cl3(cl3),
    .cmd(cmd), .ba(sd_ba), .a(sd_a), .dqm(sd_dqm), .dq_out(sd_dq_o), .dq_oe(sd_dq_oe)
  );

  sdram_rd_pipe u_rd (
    .clk(clk), .rst_n(rst_n), .cl3(cl3), .rd_on_bus(cmd == CMD_RD),
    .dq_in(sd_dq_i), .rdata(rd_data_o), .rvalid(rd_valid_o)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  assert_serve_only_when_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_serve |-> ref_pending);
endmodule

// File: tb/sdram_seq_ctrl_test.sv
module sdram_seq_ctrl_test;
  localparam int CLK_MHZ = 50, PWRUP_US = 100, REF_NS = 15625;
  localparam int TRCD = 3, TRP = 3, TRFC = 7, TMRD = 2, TWR = 2;
  localparam int REF_CYC = CLK_MHZ * REF_NS / 1000;
  localparam int SLACK = TRFC + TRCD + TWR + TRP + 3 + TMRD + 6;

  logic clk = 0, rst_n = 0, cfg_cl3 = 0;
  logic req = 0, req_we = 0;
  logic [22:0] req_addr = '0;
  logic [31:0] req_wdata = '0, sd_dq_i = '0;
  logic [3:0] req_be = '0;
  logic ack, rvalid, ready, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [31:0] rdata, dq_o;
  logic [1:0] ba;
  logic [11:0] a;
  logic [3:0] dqm;

  always #10 clk = ~clk;

  sdram_seq_ctrl #(.CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .REF_NS(REF_NS), .TRCD(TRCD),
                   .TRP(TRP), .TRFC(TRFC), .TMRD(TMRD), .TWR(TWR)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_cl3(cfg_cl3), .req_i(req), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be), .ack_o(ack),
    .rd_data_o(rdata), .rd_valid_o(rvalid), .ready_o(ready), .sd_cs_n(cs_n),
    .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(ba), .sd_a(a),
    .sd_dqm(dqm), .sd_dq_o(dq_o), .sd_dq_oe(dq_oe), .sd_dq_i(sd_dq_i));

  int ncheck = 0, nfail = 0;
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncheck++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] init_word(input logic [22:0] ad);
    return {ad, 9'h0} ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = be[i] ? nw[i*8 +: 8] : old[i*8 +: 8];
    return r;
  endfunction
  function automatic int min_gap(input logic [3:0] c, input int cl);
    case (c)
      4'b0010: return TRP;
      4'b0001: return TRFC;
      4'b0000: return TMRD;
      4'b0011: return TRCD;
      4'b0100: return TWR + TRP;
      4'b0101: return cl + TRP;
      default: return 0;
    endcase
  endfunction

  // ---------------- DRAM model and command-stream checks ----------------
  logic [31:0] dev_mem [int];
  logic [31:0] ref_mem [int];
  logic [22:0] exp_addr;
  logic [31:0] exp_wd;
  logic [3:0]  exp_be;
  int cyc = 0, last_cmd_cyc, last_ref_cyc, act_cyc, rd_s, rd_cnt, dev_cl, ref_n, rw_n = 0, ref_live_n;
  bit pre_seen, mrs_seen, rdy_seen;
  logic [3:0] last_cmd;
  logic [11:0] open_row [4];
  logic [31:0] rd_word;

  always @(posedge clk) begin
    logic [3:0] c;
    int key;
    cyc++;
    c = {cs_n, ras_n, cas_n, we_n};
    if (!rst_n) begin
      pre_seen = 0; mrs_seen = 0; rdy_seen = 0; ref_n = 0; ref_live_n = 0;
      rd_cnt = 0; last_cmd = 4'b0111; last_cmd_cyc = 0; last_ref_cyc = 0;
      sd_dq_i <= 32'hDEAD_BEEF;
    end else begin
      if (ready) rdy_seen = 1;
      if (rvalid) check(cyc == rd_s + dev_cl + 1, "R7 read strobe cycle", cyc, rd_s + dev_cl + 1);
      if (rd_cnt > 0) rd_cnt--;
      if (c != 4'b0111) begin
        check(c inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101}, "R3 command code", c, 0);
        if (last_cmd != 4'b0111)
          check(cyc - last_cmd_cyc >= min_gap(last_cmd, dev_cl), "R10 command gap",
                cyc - last_cmd_cyc, min_gap(last_cmd, dev_cl));
        last_cmd = c; last_cmd_cyc = cyc;
      end
      case (c)
        4'b0010: begin
          check(a[10] == 1'b1 && !mrs_seen, "R1 precharge all", a, 12'h400);
          pre_seen = 1;
        end
        4'b0001: begin
          ref_n++;
          if (mrs_seen) begin
            ref_live_n++;
            check(cyc - last_ref_cyc <= REF_CYC + SLACK, "R8 refresh spacing", cyc - last_ref_cyc, REF_CYC + SLACK);
          end
          last_ref_cyc = cyc;
        end
        4'b0000: begin
          check(pre_seen && ref_n == 2 && !ready, "R1 init order", ref_n, 2);
          check(a == {5'b0, (cfg_cl3 ? 3'd3 : 3'd2), 4'b0} && ba == 2'b0, "R2 mode word", a,
                {5'b0, (cfg_cl3 ? 3'd3 : 3'd2), 4'b0});
          dev_cl = cfg_cl3 ? 3 : 2;
          mrs_seen = 1;
        end
        4'b0011: begin
          check({ba, a} == exp_addr[22:9], "R4 activate bank/row", {ba, a}, exp_addr[22:9]);
          open_row[ba] = a; act_cyc = cyc;
        end
        4'b0100, 4'b0101: begin
          check(cyc - act_cyc == TRCD, "R5 activate to column", cyc - act_cyc, TRCD);
          check({ba, a} == {exp_addr[22:21], 3'b010, exp_addr[8:0]}, "R4 column word",
                {ba, a}, {exp_addr[22:21], 3'b010, exp_addr[8:0]});
          key = int'({ba, open_row[ba], a[8:0]});
          if (!dev_mem.exists(key)) dev_mem[key] = init_word(23'(key));
          if (c == 4'b0100) begin
            check(dq_oe && dqm == ~exp_be && dq_o == exp_wd, "R6 write data/mask", {dq_oe, dqm, dq_o[26:0]},
                  {1'b1, ~exp_be, exp_wd[26:0]});
            dev_mem[key] = merge(dev_mem[key], dq_o, ~dqm);
          end else begin
            check(!dq_oe && dqm == 4'b0000, "R6 read mask", {dq_oe, dqm}, 0);
            rd_word = dev_mem[key]; rd_cnt = dev_cl; rd_s = cyc;
          end
          rw_n++;
        end
        default: ;
      endcase
      sd_dq_i <= (rd_cnt == 1) ? rd_word : 32'hDEAD_BEEF;
    end
  end

  // ---------------- host side ----------------
  task automatic host_req(input logic we, input logic [22:0] ad, input logic [31:0] wd, input logic [3:0] be);
    int n0, t;
    logic [31:0] exp;
    exp_addr = ad; exp_wd = wd; exp_be = we ? be : 4'h0;
    n0 = rw_n;
    @(negedge clk);
    req = 1; req_we = we; req_addr = ad; req_wdata = wd; req_be = be;
    t = 0;
    do begin @(negedge clk); t++; end while (!ack && t < 2000);
    req = 0;
    check(ack, "R9 ack arrives", ack, 1);
    @(negedge clk);
    check(!ack, "R9 ack one cycle", ack, 0);
    while (rw_n == n0 && t < 4000) begin @(negedge clk); t++; end
    if (!ref_mem.exists(int'(ad))) ref_mem[int'(ad)] = init_word(ad);
    if (we) ref_mem[int'(ad)] = merge(ref_mem[int'(ad)], wd, be);
    else begin
      while (!rvalid && t < 4000) begin @(negedge clk); t++; end
      exp = ref_mem[int'(ad)];
      check(rvalid && rdata == exp, "R7 read data", rdata, exp);
    end
  endtask

  function automatic logic [22:0] pick_addr();
    int r = $urandom_range(0, 9);
    if (r == 0) return 23'h0;
    if (r == 1) return 23'h7F_FFFF;
    return {2'($urandom_range(0, 3)), 12'($urandom_range(0, 2) * 12'h7FF), 9'($urandom_range(0, 7))};
  endfunction

  task automatic run_phase(input logic cl3);
    int t, refs0;
    cfg_cl3 = cl3;
    rst_n = 0;
    repeat (4) @(negedge clk);
    check(!ready && cs_n == 0 && {ras_n, cas_n, we_n} == 3'b111, "R1 reset state", {ready, cs_n, ras_n, cas_n, we_n}, 5'b00111);
    rst_n = 1;
    t = 0;
    while (!ready && t < 20000) begin @(negedge clk); t++; end
    check(ready && mrs_seen, "R1 ready after init", ready, 1);
    cfg_cl3 = ~cl3;   // must not change the latency (R2)
    host_req(1, 23'h7F_FFFF, 32'hCAFE_F00D, 4'hF);
    host_req(0, 23'h7F_FFFF, 0, 0);
    host_req(1, 23'h0, 32'h1122_3344, 4'b0101);
    host_req(0, 23'h0, 0, 0);
    for (int i = 0; i < 300; i++) begin
      logic w = 1'($urandom_range(0, 1));
      host_req(w, pick_addr(), $urandom(), 4'($urandom_range(0, 15)));
    end
    refs0 = ref_live_n;
    repeat (REF_CYC + SLACK) @(negedge clk);
    check(ref_live_n > refs0, "R8 refresh while idle", ref_live_n, refs0 + 1);
    check(ready, "R1 ready sticky", ready, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_phase(1'b0);
    ref_mem.delete(); dev_mem.delete();
    run_phase(1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    ncheck++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  end
endmodule